// File: doc/BRIEF.md
# Reset Classifier and Boot Vector Fetcher

This block sits between the chip's reset and non-maskable-interrupt pins and the processor core. It synchronises both pins and accepts a reset request only when the reset pin has stayed low long enough. At the moment a request is accepted, it samples the interrupt pin to decide the reset kind. A full power-up style reset clears the CPU state and every peripheral register group. A warm reset clears the CPU state and most peripheral groups, but leaves the bus-controller, pin-function and I/O-port groups untouched.

When the reset pin is released, the block reads two words from memory over a request/ready handshake. The first word is the initial program counter and the second is the initial stack pointer. It then presents both values with a one-cycle done pulse and releases the CPU from reset. Reset fetches use absolute addresses. For every other exception, the block computes the vector address from a base register, and it suppresses that address whenever a reset is in progress.

Top module: `rst_vector_seq`

## Requirements
- R1: Both pins pass through a two-flop synchroniser. A low level on `rst_pin_n` is accepted only once the synchronised level has been low for MIN_LOW (default 20) consecutive cycles. A shorter low pulse changes no output: `cpu_rst_o` stays low, no memory read starts and no done pulse appears.
- R2: The reset kind is latched from the synchronised `nmi_pin` in the cycle the request is accepted. A high level selects a power-up reset (`por_o`=1) and a low level selects a warm reset (`por_o`=0).
- R3: Each bit of `periph_rst_o` clears one peripheral register group. Bit 0 is the bus controller, bit 1 is pin function and bit 2 is I/O ports. After an accepted power-up reset all bits are 1. After an accepted warm reset, bits 0 to 2 are 0 and all other bits are 1. The bits stay in that state until the synchronised reset pin goes high, and then they all drop to 0.
- R4: `cpu_rst_o` rises one cycle after a request is accepted and stays high until the cycle the done pulse appears. Memory reads are issued only while it is high.
- R5: The fetch reads the PC word first and then the SP word. For a power-up reset the addresses are 0 and 4 (vectors 0 and 1). For a warm reset they are 8 and 12 (vectors 2 and 3). The base register is not added to either.
- R6: Each read holds `mem_req_o` high and `mem_addr_o` stable until `mem_rdy_i` is sampled high. The data is taken from `mem_data_i` in that same cycle.
- R7: After the SP word is taken, `done_o` is high for exactly one cycle. At that point `init_pc_o` and `init_sp_o` hold the two words that were read.
- R8: When `exc_req_i` is sampled high while the block is running, then one cycle later `exc_valid_o` is 1 and `exc_addr_o` equals `vbr_i + 4*exc_vec_i` modulo 2^ADDR_W. With no request, `exc_valid_o` is 0.
- R9: Reset takes priority over other exceptions. `exc_valid_o` is never 1 while `cpu_rst_o` is high, nor in the cycle after a request is accepted.
- R10: A new accepted reset during the fetch abandons the read in progress and restarts classification and fetching. Only one done pulse follows, carrying the vectors of the new reset kind.
- R11: After the block's own reset `rst`: `cpu_rst_o` is 1, all `periph_rst_o` bits are 1, and `mem_req_o` and `done_o` are 0. The block then waits, issuing no read, until a pin reset is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_pin_n | input | 1 | Asynchronous active-low reset request pin |
| nmi_pin | input | 1 | Asynchronous non-maskable-interrupt level pin |
| cpu_rst_o | output | 1 | Holds the CPU state in reset |
| periph_rst_o | output | NDOM | Per-group peripheral register clear |
| por_o | output | 1 | Latched reset kind, 1 = power-up |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | ADDR_W | Read address |
| mem_rdy_i | input | 1 | Read data valid / request accepted |
| mem_data_i | input | DATA_W | Read data |
| done_o | output | 1 | One-cycle pulse when both words are loaded |
| init_pc_o | output | DATA_W | Initial program counter |
| init_sp_o | output | DATA_W | Initial stack pointer |
| exc_req_i | input | 1 | Request for an exception vector address |
| exc_vec_i | input | VEC_W | Exception vector number |
| vbr_i | input | ADDR_W | Vector base register |
| exc_valid_o | output | 1 | Exception address valid |
| exc_addr_o | output | ADDR_W | Exception vector address |

## Verification
The bench builds the block with ADDR_W=16 and leaves MIN_LOW=20, NDOM=6 and VEC_W=8 at their defaults. With a 16-bit address, the full range of 256 vector numbers can be swept against base values that wrap the address, including one near the top. The sweep covers every low-pulse length from 1 to 24 cycles under both interrupt levels and two ready latencies, so the 19/20-cycle boundary and both reset kinds are exercised in every combination. A slow memory setting keeps the fetch open long enough for a second reset to land in the middle of a read.

// File: rtl/rstvec_pkg.sv
package rstvec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_FPC,
    ST_FSP,
    ST_RUN
  } seq_state_t;

  // Byte offset of a reset vector: vector = {warm, sp_word}, 4 bytes each.
  function automatic logic [31:0] reset_vec_offset(input logic por, input logic sp_word);
    return {28'd0, ~por, sp_word, 2'b00};
  endfunction

endpackage

// File: rtl/rv_sync.sv
module rv_sync #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1[i] <= RST_VAL[i];
        q_o[i]    <= RST_VAL[i];
      end else begin
        stage1[i] <= d_i[i];
        q_o[i]    <= stage1[i];
      end
    end
  end
endmodule

// File: rtl/rv_pulse_qual.sv
module rv_pulse_qual #(
  parameter int MIN_LOW = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic low_i,
  output logic qual_o
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !low_i) begin
      cnt <= '0;
    end else if (cnt != CW'(MIN_LOW)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign qual_o = low_i && (cnt == CW'(MIN_LOW - 1));

  AST_QUAL_ONCE: assert property (@(posedge clk) disable iff (rst)
    qual_o |=> !qual_o); // R1
endmodule

// File: rtl/rv_fetch_seq.sv
module rv_fetch_seq
  import rstvec_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              DATA_W    = 32,
  parameter int              NDOM      = 6,
  parameter logic [NDOM-1:0] KEEP_MASK = {{(NDOM-3){1'b0}}, 3'b111}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_low_i,
  input  logic              nmi_i,
  input  logic              qual_i,
  input  logic              mem_rdy_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              cpu_rst_o,
  output logic [NDOM-1:0]   periph_rst_o,
  output logic              por_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              done_o,
  output logic [DATA_W-1:0] init_pc_o,
  output logic [DATA_W-1:0] init_sp_o,
  output logic              run_o
);
  localparam logic [NDOM-1:0] ALL_DOM  = '1;
  localparam logic [NDOM-1:0] WARM_DOM = ALL_DOM & ~KEEP_MASK;

  seq_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cpu_rst_o    <= 1'b1;
      periph_rst_o <= ALL_DOM;
      por_o        <= 1'b1;
      mem_req_o    <= 1'b0;
      mem_addr_o   <= '0;
      done_o       <= 1'b0;
      init_pc_o    <= '0;
      init_sp_o    <= '0;
    end else begin
      done_o <= 1'b0;
      if (qual_i) begin
        state        <= ST_HOLD;
        cpu_rst_o    <= 1'b1;
        por_o        <= nmi_i;
        periph_rst_o <= nmi_i ? ALL_DOM : WARM_DOM;
        mem_req_o    <= 1'b0;
      end else begin
        case (state)
          ST_HOLD: if (!pin_low_i) begin
            periph_rst_o <= '0;
            mem_req_o    <= 1'b1;
            mem_addr_o   <= ADDR_W'(reset_vec_offset(por_o, 1'b0));
            state        <= ST_FPC;
          end
          ST_FPC: if (mem_rdy_i) begin
            init_pc_o  <= mem_data_i;
            mem_addr_o <= ADDR_W'(reset_vec_offset(por_o, 1'b1));
            state      <= ST_FSP;
          end
          ST_FSP: if (mem_rdy_i) begin
            init_sp_o <= mem_data_i;
            mem_req_o <= 1'b0;
            done_o    <= 1'b1;
            cpu_rst_o <= 1'b0;
            state     <= ST_RUN;
          end
          default: ;
        endcase
      end
    end
  end

  assign run_o = (state == ST_RUN);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_rdy_i && !qual_i) |=> (mem_req_o && $stable(mem_addr_o))); // R6
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_CPU_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_rst_o) |-> done_o); // R4
  AST_FETCH_IN_RST: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> cpu_rst_o); // R4
  AST_WARM_KEEP: assert property (@(posedge clk) disable iff (rst)
    (cpu_rst_o && !por_o) |-> ((periph_rst_o & KEEP_MASK) == '0)); // R3
  AST_PC_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_o) |-> (mem_addr_o == (por_o ? ADDR_W'(0) : ADDR_W'(8)))); // R5
endmodule

// File: rtl/rv_exc_addr.sv
module rv_exc_addr #(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blocked_i,
  input  logic              exc_req_i,
  input  logic [VEC_W-1:0]  exc_vec_i,
  input  logic [ADDR_W-1:0] vbr_i,
  output logic              exc_valid_o,
  output logic [ADDR_W-1:0] exc_addr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      exc_valid_o <= 1'b0;
      exc_addr_o  <= '0;
    end else begin
      exc_valid_o <= exc_req_i && !blocked_i;
      exc_addr_o  <= vbr_i + (ADDR_W'(exc_vec_i) << 2);
    end
  end

  AST_EXC_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    blocked_i |=> !exc_valid_o); // R9
  AST_EXC_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !exc_req_i |=> !exc_valid_o); // R8
endmodule

// File: rtl/rst_vector_seq.sv
module rst_vector_seq #(
  parameter int              MIN_LOW   = 20,
  parameter int              ADDR_W    = 32,
  parameter int              DATA_W    = 32,
  parameter int              NDOM      = 6,
  parameter int              VEC_W     = 8,
  parameter logic [NDOM-1:0] KEEP_MASK = {{(NDOM-3){1'b0}}, 3'b111}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_pin_n,
  input  logic              nmi_pin,
  output logic              cpu_rst_o,
  output logic [NDOM-1:0]   periph_rst_o,
  output logic              por_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rdy_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              done_o,
  output logic [DATA_W-1:0] init_pc_o,
  output logic [DATA_W-1:0] init_sp_o,
  input  logic              exc_req_i,
  input  logic [VEC_W-1:0]  exc_vec_i,
  input  logic [ADDR_W-1:0] vbr_i,
  output logic              exc_valid_o,
  output logic [ADDR_W-1:0] exc_addr_o
);
  logic [1:0] pins_s;
  logic       qual;
  logic       run;

  rv_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({nmi_pin, rst_pin_n}),
    .q_o (pins_s)
  );

  rv_pulse_qual #(.MIN_LOW(MIN_LOW)) u_qual (
    .clk    (clk),
    .rst    (rst),
    .low_i  (!pins_s[0]),
    .qual_o (qual)
  );

  rv_fetch_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NDOM(NDOM), .KEEP_MASK(KEEP_MASK)
  ) u_fetch (
    .clk          (clk),
    .rst          (rst),
    .pin_low_i    (!pins_s[0]),
    .nmi_i        (pins_s[1]),
    .qual_i       (qual),
    .mem_rdy_i    (mem_rdy_i),
    .mem_data_i   (mem_data_i),
    .cpu_rst_o    (cpu_rst_o),
    .periph_rst_o (periph_rst_o),
    .por_o        (por_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .done_o       (done_o),
    .init_pc_o    (init_pc_o),
    .init_sp_o    (init_sp_o),
    .run_o        (run)
  );

  rv_exc_addr #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_exc (
    .clk         (clk),
    .rst         (rst),
    .blocked_i   (!run || qual),
    .exc_req_i   (exc_req_i),
    .exc_vec_i   (exc_vec_i),
    .vbr_i       (vbr_i),
    .exc_valid_o (exc_valid_o),
    .exc_addr_o  (exc_addr_o)
  );
endmodule

// File: tb/rst_vector_seq_test.sv
module rst_vector_seq_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int ND = 6;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rst_pin_n = 1'b1;
  logic          nmi_pin = 1'b1;
  logic          cpu_rst_o;
  logic [ND-1:0] periph_rst_o;
  logic          por_o;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rdy_i = 1'b0;
  logic [DW-1:0] mem_data_i;
  logic          done_o;
  logic [DW-1:0] init_pc_o, init_sp_o;
  logic          exc_req_i = 1'b0;
  logic [VW-1:0] exc_vec_i = '0;
  logic [AW-1:0] vbr_i = '0;
  logic          exc_valid_o;
  logic [AW-1:0] exc_addr_o;

  rst_vector_seq #(.ADDR_W(AW), .DATA_W(DW), .NDOM(ND), .VEC_W(VW)) uut (
    .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .nmi_pin(nmi_pin),
    .cpu_rst_o(cpu_rst_o), .periph_rst_o(periph_rst_o), .por_o(por_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdy_i(mem_rdy_i),
    .mem_data_i(mem_data_i), .done_o(done_o), .init_pc_o(init_pc_o),
    .init_sp_o(init_sp_o), .exc_req_i(exc_req_i), .exc_vec_i(exc_vec_i),
    .vbr_i(vbr_i), .exc_valid_o(exc_valid_o), .exc_addr_o(exc_addr_o)
  );

  always #5 clk = ~clk;

  assign mem_data_i = {16'h5A5A, mem_addr_o};

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // memory model: drives ready 1 ns after the edge
  int lat  = 0;
  int wcnt = 0;
  logic [AW-1:0] alog [0:3];
  int nlog = 0;
  always @(posedge clk) begin
    #1;
    if (mem_req_o) begin
      if (wcnt >= lat) begin
        mem_rdy_i = 1'b1;
        wcnt = 0;
        if (nlog < 4) alog[nlog] = mem_addr_o;
        nlog++;
      end else begin
        mem_rdy_i = 1'b0;
        wcnt++;
      end
    end else begin
      mem_rdy_i = 1'b0;
      wcnt = 0;
    end
  end

  // monitor
  int done_cnt = 0;
  bit saw_rst = 1'b0;
  bit cap_ok = 1'b0;
  logic [ND-1:0] cap_periph;
  int exc_bad = 0;
  int hold_bad = 0;
  bit prev_pend = 1'b0;
  logic [AW-1:0] prev_addr;
  always @(negedge clk) begin
    if (!rst) begin
      if (done_o) done_cnt++;
      if (cpu_rst_o) begin
        saw_rst = 1'b1;
        if (!cap_ok) begin cap_periph = periph_rst_o; cap_ok = 1'b1; end
      end
      if (exc_valid_o && cpu_rst_o) exc_bad++;
      if (prev_pend && (!mem_req_o || mem_addr_o != prev_addr)) hold_bad++;
      prev_pend = mem_req_o && !mem_rdy_i;
      prev_addr = mem_addr_o;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    done_cnt = 0; saw_rst = 1'b0; cap_ok = 1'b0; exc_bad = 0; hold_bad = 0; nlog = 0;
  endtask

  task automatic pulse(input int len, input bit nmi);
    @(negedge clk);
    nmi_pin = nmi;
    repeat (3) @(negedge clk);
    rst_pin_n = 1'b0;
    repeat (len) @(negedge clk);
    rst_pin_n = 1'b1;
  endtask

  task automatic check_boot(input bit nmi, input string tag);
    logic [15:0] pc_a, sp_a;
    pc_a = nmi ? 16'h0000 : 16'h0008;
    sp_a = nmi ? 16'h0004 : 16'h000C;
    chk(done_cnt == 1, {tag, " R7 done count"}, done_cnt, 1);
    chk(init_pc_o == {16'h5A5A, pc_a}, {tag, " R5 R7 pc"}, init_pc_o, {16'h5A5A, pc_a});
    chk(init_sp_o == {16'h5A5A, sp_a}, {tag, " R5 R7 sp"}, init_sp_o, {16'h5A5A, sp_a});
    chk(nlog == 2 && alog[0] == pc_a && alog[1] == sp_a, {tag, " R5 order"},
        {alog[0], alog[1]}, {pc_a, sp_a});
    chk(por_o == nmi, {tag, " R2 kind"}, por_o, nmi);
    chk(cap_periph == (nmi ? 6'h3F : 6'h38), {tag, " R3 groups"}, cap_periph, nmi ? 6'h3F : 6'h38);
    chk(!cpu_rst_o && periph_rst_o == '0, {tag, " R4 R3 release"}, {cpu_rst_o, periph_rst_o}, 0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cpu_rst_o == 1'b1, "R11 cpu_rst", cpu_rst_o, 1);
    chk(periph_rst_o == 6'h3F, "R11 periph", periph_rst_o, 6'h3F);
    chk(!mem_req_o && !done_o, "R11 idle", {mem_req_o, done_o}, 0);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    chk(cpu_rst_o && !mem_req_o && nlog == 0, "R11 waits", {cpu_rst_o, mem_req_o}, 2'b10);

    // first power-up boot
    clear_mon();
    pulse(25, 1'b1);
    repeat (40) @(negedge clk);
    check_boot(1'b1, "boot");

    // sweep pulse length x kind x latency; base register nonzero, reset ignores it
    vbr_i = 16'hFFF0;
    for (int l = 0; l < 2; l++) begin
      lat = (l == 0) ? 0 : 2;
      for (int n = 0; n < 2; n++) begin
        for (int len = 1; len <= 24; len++) begin
          clear_mon();
          exc_req_i = 1'b1;
          pulse(len, n[0]);
          repeat (40) @(negedge clk);
          exc_req_i = 1'b0;
          if (len >= 20) begin
            check_boot(n[0], "sweep");
            chk(hold_bad == 0, "R6 request held", hold_bad, 0);
          end else begin
            chk(done_cnt == 0 && !saw_rst && nlog == 0, "R1 short pulse ignored",
                {saw_rst, 8'(done_cnt)}, 0);
          end
          chk(exc_bad == 0, "R9 no exception during reset", exc_bad, 0);
        end
      end
    end

    // R9 explicit: exception request held through a long reset
    clear_mon();
    exc_req_i = 1'b1;
    @(negedge clk);
    rst_pin_n = 1'b0;
    repeat (30) @(negedge clk);
    chk(cpu_rst_o && !exc_valid_o, "R9 blocked in hold", {cpu_rst_o, exc_valid_o}, 2'b10);
    rst_pin_n = 1'b1;
    exc_req_i = 1'b0;
    repeat (40) @(negedge clk);

    // R10 restart during fetch
    lat = 30;
    clear_mon();
    pulse(25, 1'b1);
    for (int w = 0; w < 100 && !mem_req_o; w++) @(negedge clk);
    chk(mem_req_o && nlog == 0, "R10 fetch open", mem_req_o, 1);
    nmi_pin = 1'b0;
    repeat (3) @(negedge clk);
    rst_pin_n = 1'b0;
    repeat (25) @(negedge clk);
    rst_pin_n = 1'b1;
    repeat (150) @(negedge clk);
    chk(done_cnt == 1, "R10 single done", done_cnt, 1);
    chk(init_pc_o == 32'h5A5A0008 && init_sp_o == 32'h5A5A000C, "R10 warm vectors",
        init_pc_o, 32'h5A5A0008);
    chk(por_o == 1'b0, "R10 R2 kind", por_o, 0);
    lat = 0;

    // R8 exception address sweep
    for (int b = 0; b < 3; b++) begin
      logic [AW-1:0] base;
      base = (b == 0) ? 16'h0000 : (b == 1) ? 16'h1234 : 16'hFFF0;
      for (int v = 0; v < 256; v++) begin
        logic [AW-1:0] exp_a;
        exp_a = base + 16'(v * 4);
        exc_req_i = 1'b1;
        exc_vec_i = 8'(v);
        vbr_i = base;
        @(negedge clk);
        chk(exc_valid_o && exc_addr_o == exp_a, "R8 exception address", exc_addr_o, exp_a);
      end
    end
    exc_req_i = 1'b0;
    @(negedge clk);
    chk(!exc_valid_o, "R8 no request", exc_valid_o, 0);

    report();
  end
endmodule